// File: doc/BRIEF.md
# Packet-Command PIO Read Sequencer

This block is the device side of a packet-command read in programmed I/O mode. The host programs a byte-count limit and issues the packet opcode through a small set of task-file registers. It then writes a 12-byte command packet as six 16-bit words into the data port. The sequencer decodes a READ(10) packet and fetches the requested 2048-byte blocks word by word from a synchronous block source. It hands the data to the host through the data port, in bursts that never exceed the host's limit.

The sequencer announces each burst with an interrupt and with DRQ in the status register. Before the data words of a burst, it writes that burst's byte count back into the two limit registers and reports the interrupt reason. When the last word has been read, it raises a completion interrupt and drops DRQ. A host that sets bit 0 of the feature register when it issues the opcode selects DMA for the data phase. The sequencer then only flags that choice on an output and skips the PIO data phase.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register reads 0x40 (DRDY only), `irq` is low and `dma_sel` is low.
- R2: Writing 0xA0 to register 7 while idle makes status read 0xC0 (BSY, DRDY) for BSY_CYCLES cycles. Status then reads 0x48 (DRQ, DRDY, with BSY, DF and ERR clear) and the sector-count register (2) reads 1 (C/D=1, I/O=0) while the packet is accepted.
- R3: The packet's six words are taken little-endian. Byte 0 = 0x28 selects READ(10), bytes 2..5 form a big-endian LBA and bytes 7..8 form a big-endian block count. The first block fetch uses that LBA on `src_lba`.
- R4: Each burst carries min(limit, remaining) bytes, where the limit is {reg 5, reg 4} as latched at opcode time. Its byte count reads back from reg 4 (low byte) and reg 5 (high byte) during the burst.
- R5: An odd limit is used as limit-1, except for a final burst whose remaining byte count is below the limit.
- R6: At the start of each burst `irq` rises, status reads 0x48 and the sector-count register reads 2 (I/O=1, C/D=0).
- R7: The data words arrive in order, word 0 to 1023 of each block, and the LBA increments at each block boundary.
- R8: After the last word of the last burst, `irq` rises, status reads 0x40 and the sector-count register reads 3.
- R9: A read of the status register clears `irq`.
- R10: A block count of 0 ends the command after the packet, with no data phase and a single completion interrupt.
- R11: Feature bit 0 set at opcode time drives `dma_sel` high and ends the command after the packet without a PIO data phase. A later command with the bit clear drives `dma_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe (read side effects) |
| hst_addr | input | 3 | Register index: 0 data, 1 feature, 2 sector count/reason, 4 count low, 5 count high, 7 status/command |
| hst_wdata | input | 16 | Write data (8-bit registers use bits 7:0) |
| hst_rdata | output | 16 | Combinational read data for `hst_addr` |
| irq | output | 1 | Interrupt request |
| dma_sel | output | 1 | DMA data phase selected by the last command |
| src_rd | output | 1 | Block source fetch strobe |
| src_lba | output | 32 | Block address of the fetch |
| src_word | output | 10 | Word index within the block |
| src_data | input | 16 | Fetched word, valid the cycle after `src_rd` |

## Verification
The bench aims at the burst arithmetic. An odd limit that spans several blocks must lose a byte on every full burst. An odd limit of 1001 over one block must end in a 48-byte tail. A limit equal to the block size must give a single burst. A design that skips the rounding, or applies it to the short tail, returns the wrong count in registers 4/5 and desynchronises the data stream. Each data word is compared against a pattern keyed by LBA and word index, so a missed block-boundary LBA increment or an off-by-one prefetch shows up as a data mismatch. The zero-count and DMA-selected commands must produce exactly one completion interrupt and never raise DRQ. A design that entered the data phase for them would hang with DRQ set.

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq #(
  parameter int BLOCK_BYTES = 2048,
  parameter int BSY_CYCLES  = 4,
  parameter int LBA_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_wr,
  input  logic             hst_rd,
  input  logic [2:0]       hst_addr,
  input  logic [15:0]      hst_wdata,
  output logic [15:0]      hst_rdata,
  output logic             irq,
  output logic             dma_sel,
  output logic             src_rd,
  output logic [LBA_W-1:0] src_lba,
  output logic [$clog2(BLOCK_BYTES/2)-1:0] src_word,
  input  logic [15:0]      src_data
);
  localparam int BSH  = $clog2(BLOCK_BYTES);
  localparam int WW   = $clog2(BLOCK_BYTES/2);
  localparam int RW   = 16 + BSH;
  localparam int CW   = $clog2(BSY_CYCLES + 1);
  localparam logic [WW-1:0] LAST_W = WW'(BLOCK_BYTES/2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_HP0, S_PKT, S_DEC, S_PREP, S_FILL, S_XFER} st_t;
  st_t st;

  logic [7:0]       feat_q;
  logic [15:0]      bcr_q, lim_q;
  logic [1:0]       rsn_q;
  logic [CW-1:0]    cnt_q;
  logic [2:0]       pidx_q;
  logic [15:0]      pkt_q [6];
  logic [RW-1:0]    rem_q;
  logic [14:0]      wleft_q;
  logic [LBA_W-1:0] lba_q;
  logic [WW-1:0]    word_q;
  logic [15:0]      data_q;
  logic             fetch_q;

  wire rd_stat = hst_rd && hst_addr == 3'd7;
  wire rd_data = hst_rd && hst_addr == 3'd0 && st == S_XFER;
  wire wr_data = hst_wr && hst_addr == 3'd0 && st == S_PKT;
  wire go_cmd  = hst_wr && hst_addr == 3'd7 && st == S_IDLE && hst_wdata[7:0] == 8'hA0;

  wire bsy = st == S_HP0 || st == S_DEC || st == S_PREP || st == S_FILL;
  wire drq = st == S_PKT || st == S_XFER;
  wire [7:0] status = {bsy, 1'b1, 2'b00, drq, 3'b000};

  wire [7:0]       p_op  = pkt_q[0][7:0];
  wire [LBA_W-1:0] p_lba = LBA_W'({pkt_q[1][7:0], pkt_q[1][15:8], pkt_q[2][7:0], pkt_q[2][15:8]});
  wire [15:0]      p_cnt = {pkt_q[3][15:8], pkt_q[4][7:0]};
  wire             dec_end = dma_sel || p_op != 8'h28 || p_cnt == 16'd0;

  wire [15:0] lim_even = {lim_q[15:1], 1'b0};
  wire [15:0] lim_eff  = (lim_even == 16'd0) ? 16'd2 : lim_even;
  wire [15:0] burst    = (rem_q < RW'(lim_q)) ? rem_q[15:0] : lim_eff;

  wire             wrap     = word_q == LAST_W;
  wire [WW-1:0]    nxt_word = wrap ? '0 : word_q + 1'b1;
  wire [LBA_W-1:0] nxt_lba  = wrap ? lba_q + 1'b1 : lba_q;
  wire             last_rd  = rd_data && wleft_q == 15'd1;

  assign src_rd   = st == S_PREP || (rd_data && !last_rd);
  assign src_word = (st == S_XFER) ? nxt_word : word_q;
  assign src_lba  = (st == S_XFER) ? nxt_lba : lba_q;

  always_comb begin
    case (hst_addr)
      3'd0:    hst_rdata = (st == S_XFER) ? data_q : 16'h0000;
      3'd1:    hst_rdata = {8'h00, feat_q};
      3'd2:    hst_rdata = {14'h0000, rsn_q};
      3'd4:    hst_rdata = {8'h00, bcr_q[7:0]};
      3'd5:    hst_rdata = {8'h00, bcr_q[15:8]};
      3'd7:    hst_rdata = {8'h00, status};
      default: hst_rdata = 16'h0000;
    endcase
  end

  wire irq_set = st == S_FILL || (st == S_DEC && dec_end) || (last_rd && rem_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (rd_stat) irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      data_q  <= '0;
    end else begin
      fetch_q <= src_rd;
      if (fetch_q) data_q <= src_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_q <= '0;
      bcr_q  <= '0;
    end else begin
      if (hst_wr && st == S_IDLE) begin
        if (hst_addr == 3'd1) feat_q <= hst_wdata[7:0];
        if (hst_addr == 3'd4) bcr_q[7:0] <= hst_wdata[7:0];
        if (hst_addr == 3'd5) bcr_q[15:8] <= hst_wdata[7:0];
      end
      if (st == S_PREP) bcr_q <= burst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pidx_q <= '0;
      for (int i = 0; i < 6; i++) pkt_q[i] <= '0;
    end else if (go_cmd) begin
      pidx_q <= '0;
    end else if (wr_data) begin
      pkt_q[pidx_q] <= hst_wdata;
      pidx_q <= pidx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      rsn_q   <= 2'd0;
      dma_sel <= 1'b0;
      rem_q   <= '0;
      wleft_q <= '0;
      lba_q   <= '0;
      word_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (go_cmd) begin
          st      <= S_HP0;
          cnt_q   <= '0;
          lim_q   <= bcr_q;
          dma_sel <= feat_q[0];
        end
        S_HP0: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(BSY_CYCLES - 1)) begin
            st    <= S_PKT;
            rsn_q <= 2'd1;
          end
        end
        S_PKT: if (wr_data && pidx_q == 3'd5) st <= S_DEC;
        S_DEC: begin
          if (dec_end) begin
            st    <= S_IDLE;
            rsn_q <= 2'd3;
          end else begin
            st     <= S_PREP;
            rem_q  <= RW'(p_cnt) << BSH;
            lba_q  <= p_lba;
            word_q <= '0;
          end
        end
        S_PREP: begin
          rem_q   <= rem_q - RW'(burst);
          wleft_q <= burst[15:1];
          rsn_q   <= 2'd2;
          st      <= S_FILL;
        end
        S_FILL: st <= S_XFER;
        S_XFER: if (rd_data) begin
          word_q  <= nxt_word;
          lba_q   <= nxt_lba;
          wleft_q <= wleft_q - 1'b1;
          if (last_rd) begin
            if (rem_q == '0) begin
              st    <= S_IDLE;
              rsn_q <= 2'd3;
            end else begin
              st <= S_PREP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL |-> bcr_q <= lim_eff);
  assert_burst_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL |-> bcr_q[0] == 1'b0);
  assert_burst_reason_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL |=> irq && rsn_q == 2'd2);
  assert_prefetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |=> fetch_q);
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rd_stat && !hst_wr) |=> !irq);
  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && p_cnt == 16'd0) |=> st == S_IDLE && irq && !drq);
  assert_dma_skip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && dma_sel) |=> st == S_IDLE);
endmodule

// File: tb/test_atapi_pio_seq.sv
module test_atapi_pio_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BSY_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_wr = 1'b0, hst_rd = 1'b0;
  logic [2:0] hst_addr = '0;
  logic [15:0] hst_wdata = '0, hst_rdata;
  logic irq, dma_sel, src_rd;
  logic [31:0] src_lba;
  logic [9:0] src_word;
  logic [15:0] src_data;
  int total = 0, bad = 0;
  logic seen_q = 1'b0;
  logic [31:0] first_lba = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atapi_pio_seq #(.BLOCK_BYTES(2048), .BSY_CYCLES(BSY_CYC), .LBA_W(32)) i_atapi_pio_seq (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq), .dma_sel(dma_sel),
    .src_rd(src_rd), .src_lba(src_lba), .src_word(src_word), .src_data(src_data));

  function automatic logic [15:0] pat(input logic [31:0] l, input logic [9:0] w);
    return {l[5:0], w};
  endfunction

  always_ff @(posedge clk) begin
    if (src_rd) src_data <= pat(src_lba, src_word);
    if (src_rd && !seen_q) begin
      seen_q <= 1'b1;
      first_lba <= src_lba;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = a;
    #1 d = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, irq, 1);
  endtask

  task automatic start_cmd(input logic [15:0] lim, input logic feat, input logic [31:0] lba,
                           input logic [15:0] cnt);
    logic [15:0] d;
    int n;
    wr(3'd4, {8'h00, lim[7:0]});
    wr(3'd5, {8'h00, lim[15:8]});
    wr(3'd1, {15'h0, feat});
    wr(3'd7, 16'h00A0);
    rd(3'd7, d);
    chk("R2 busy after opcode", d, 16'h00C0);
    n = 0;
    d = 16'h0080;
    while (d[7] && n < 50) begin
      rd(3'd7, d);
      n++;
    end
    chk("R2 packet ready status", d, 16'h0048);
    rd(3'd2, d);
    chk("R2 reason command", d, 1);
    seen_q = 1'b0;
    wr(3'd0, 16'h0028);
    wr(3'd0, {lba[23:16], lba[31:24]});
    wr(3'd0, {lba[7:0], lba[15:8]});
    wr(3'd0, {cnt[15:8], 8'h00});
    wr(3'd0, {8'h00, cnt[7:0]});
    wr(3'd0, 16'h0000);
  endtask

  task automatic finish_chk();
    logic [15:0] d;
    wait_irq("R8 completion irq");
    rd(3'd2, d);
    chk("R8 reason complete", d, 3);
    rd(3'd7, d);
    chk("R8 final status", d, 16'h0040);
    chk("R9 irq cleared by status read", irq, 0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd7, d);
    chk("R1 reset status", d, 16'h0040);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset dma_sel", dma_sel, 0);
  endtask

  task automatic t_pio(input logic [15:0] lim, input logic [31:0] lba, input logic [15:0] cnt);
    logic [15:0] d, lo, hi;
    int rem, bytes, k, errs;
    start_cmd(lim, 1'b0, lba, cnt);
    rem = int'(cnt) * 2048;
    k = 0;
    while (rem > 0) begin
      bytes = (rem < int'(lim)) ? rem : int'(lim & 16'hFFFE);
      wait_irq("R6 burst irq");
      rd(3'd7, d);
      chk("R6 burst status", d, 16'h0048);
      chk("R9 irq cleared", irq, 0);
      rd(3'd2, d);
      chk("R6 burst reason", d, 2);
      rd(3'd4, lo);
      rd(3'd5, hi);
      chk(((lim[0] && rem >= int'(lim)) ? "R5 odd limit burst" : "R4 burst count"),
          {hi[7:0], lo[7:0]}, bytes);
      if (k == 0) chk("R3 first lba", first_lba, lba);
      errs = 0;
      for (int i = 0; i < bytes / 2; i++) begin
        rd(3'd0, d);
        if (d !== pat(lba + 32'(k / 1024), 10'(k % 1024))) errs++;
        k++;
      end
      chk("R7 burst data mismatches", errs, 0);
      rem -= bytes;
    end
    chk("R11 dma_sel low for pio", dma_sel, 0);
    finish_chk();
  endtask

  task automatic t_zero();
    logic [15:0] d;
    start_cmd(16'd4096, 1'b0, 32'd9, 16'd0);
    wait_irq("R10 completion irq");
    rd(3'd7, d);
    chk("R10 no data phase status", d, 16'h0040);
    rd(3'd2, d);
    chk("R10 reason complete", d, 3);
    repeat (20) @(negedge clk);
    chk("R10 single interrupt", irq, 0);
  endtask

  task automatic t_dma();
    logic [15:0] d;
    start_cmd(16'd4096, 1'b1, 32'd3, 16'd2);
    wait_irq("R11 completion irq");
    chk("R11 dma_sel high", dma_sel, 1);
    rd(3'd7, d);
    chk("R11 no pio drq", d, 16'h0040);
    repeat (20) @(negedge clk);
    chk("R11 no further irq", irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pio(16'd5121, 32'h0102_0307, 16'd3);
    t_pio(16'd1001, 32'd40, 16'd1);
    t_pio(16'd2048, 32'hA5C3_0011, 16'd1);
    t_zero();
    t_dma();
    t_pio(16'd1200, 32'd62, 16'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule